// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block sits behind a MAC receive interface and follows one received Ethernet frame at a time as a stream of octets. The stream begins at the first destination address octet and ends with the last frame check sequence octet. While the frame passes, the block records four things:

- the class of the destination address;
- the CRC-32 state over the octets it keeps;
- the number of octets received and the number kept;
- any code-group error or receive FIFO overrun reported alongside the octets.

One cycle after the closing octet it presents an 8-bit status word and the kept length, marked by a single-cycle done pulse.

A programmable maximum frame length limits the frame. The block samples this limit on the opening octet. With huge-frame mode off, octets beyond the limit are dropped and the frame is marked truncated. With huge-frame mode on, the whole frame is kept. Short-frame reporting is switched by a control input. The block is intended to feed a descriptor writer, which copies the status word and length into a receive buffer descriptor.

Top module: `rx_frame_status`

## Requirements
- R1: Status bit 0 (broadcast) is set when the frame holds at least six octets and all six destination address octets are 0xFF.
- R2: Status bit 1 (multicast) is set when bit 0 of the first destination octet is 1 and the frame is not broadcast. Bits 0 and 1 are never both set.
- R3: Status bit 2 (length violation) is set when the received octet count is greater than or equal to the maximum length. This holds whatever the huge-frame setting.
- R4: With huge-frame mode off, octets past the maximum length are dropped from the length and from the CRC. Status bit 7 (truncation) is set only when at least one octet was dropped. A frame of exactly the maximum length is not truncated.
- R5: Status bit 4 (short) is set when the kept length is below 64 octets and the short-enable input is 1. With short-enable at 0, bit 4 stays 0 for any length.
- R6: Status bit 3 (non-octet) is set when the partial-bits input is nonzero on the closing octet.
- R7: For a whole-octet frame, status bit 5 (CRC error) is set when the IEEE 802.3 CRC-32 over the kept octets, FCS included, does not leave the residue 0xC704DD7B. The CRC uses polynomial 0x04C11DB7, an all-ones start value and LSB-first octets. In the right-shifting register this residue reads 0xDEBB20E3.
- R8: Status bit 5 is also set when a code-group error is flagged with any octet of the frame, including a frame with partial bits.
- R9: An overrun flagged with any octet sets status bit 6 (overrun) and forces bits 2, 3, 5 and 7 to 0.
- R10: The reported length counts every kept octet, the 4 FCS octets included. For a truncated frame it equals the maximum length.
- R11: The maximum length is sampled on the octet that carries the start strobe. Changing it later in the frame affects only later frames.
- R12: Done is high for exactly one cycle: the cycle after the octet that carries the end strobe. Status and length are valid in that cycle, and the next frame may start in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inByteValid | input | 1 | Octet on inByte is valid this cycle |
| inByte | input | 8 | Received octet |
| inSof | input | 1 | This valid octet is the first destination address octet |
| inEof | input | 1 | This valid octet is the last octet of the frame |
| inPartialBits | input | 3 | Count of trailing bits beyond whole octets; sampled with the end strobe |
| inCodeErr | input | 1 | Code-group error seen with this valid octet |
| inOverrun | input | 1 | Receive FIFO overrun seen with this valid octet |
| cfgMaxLen | input | 16 | Maximum frame length in octets |
| cfgHugeEn | input | 1 | 1 keeps octets beyond the maximum length |
| cfgShortEn | input | 1 | 1 enables short-frame reporting |
| outDone | output | 1 | One-cycle pulse: status and length are valid |
| outStatus | output | 8 | Status word: bit0 broadcast, bit1 multicast, bit2 length violation, bit3 non-octet, bit4 short, bit5 CRC error, bit6 overrun, bit7 truncation |
| outLength | output | 16 | Kept frame length in octets |

## Verification
Random frames vary length, destination class, maximum length, huge and short settings, idle gaps, partial bits, corrupted data and the position of code-group errors and overruns. Comparing these runs against a software model separates keeping an octet from only counting it, which matters for CRC and length. It also separates a limit sampled at start from one read live. Directed frames cover the cases random draws rarely reach: exactly the maximum length against one octet more, a broadcast destination against a multicast one that is not all-ones, short frames with reporting on and off, an overrun together with a bad CRC, and a limit change in mid-frame.

// File: rtl/rx_frame_status_pkg.sv
package rx_frame_status_pkg;
  localparam int LEN_W     = 16;
  localparam int RX_W      = LEN_W + 1;
  localparam int DA_BYTES  = 6;
  localparam int DA_IDX_W  = $clog2(DA_BYTES);
  localparam int MIN_FRAME = 64;
  localparam int PART_W    = 3;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_REG  = 32'hDEBB20E3;

  typedef struct packed {
    logic truncated;
    logic overrun;
    logic crcErr;
    logic shortFrm;
    logic nonOctet;
    logic lenViol;
    logic mcast;
    logic bcast;
  } frameStatus_t;

  typedef struct packed {
    logic                startFrame;
    logic                acceptByte;
    logic                keepByte;
    logic                endFrame;
    logic                daByte;
    logic [DA_IDX_W-1:0] daIndex;
    logic                lenReached;
    logic [LEN_W-1:0]    keptNext;
    logic [RX_W-1:0]     rxNext;
  } ctlStrobes_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] din);
    logic [31:0] c;
    c = crcIn ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_frame_status_ctrl.sv
module rx_frame_status_ctrl
  import rx_frame_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inByteValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic             cfgHugeEn,
  output ctlStrobes_t      strobes
);
  localparam logic [RX_W-1:0]  RX_MAX   = '1;
  localparam logic [LEN_W-1:0] KEPT_MAX = '1;

  logic             inFrame;
  logic [RX_W-1:0]  rxCount;
  logic [LEN_W-1:0] keptCount;
  logic [LEN_W-1:0] maxLenQ;

  logic             accept;
  logic [LEN_W-1:0] effMax;
  logic [RX_W-1:0]  baseRx;
  logic [LEN_W-1:0] baseKept;
  logic             keep;

  always_comb begin
    accept   = inByteValid & (inSof | inFrame);
    effMax   = inSof ? cfgMaxLen : maxLenQ;
    baseRx   = inSof ? '0 : rxCount;
    baseKept = inSof ? '0 : keptCount;
    keep     = accept & (cfgHugeEn | (baseKept < effMax));

    strobes            = '0;
    strobes.startFrame = inByteValid & inSof;
    strobes.acceptByte = accept;
    strobes.keepByte   = keep;
    strobes.endFrame   = accept & inEof;
    strobes.daByte     = accept & (baseRx < RX_W'(DA_BYTES));
    strobes.daIndex    = baseRx[DA_IDX_W-1:0];
    strobes.rxNext     = (baseRx == RX_MAX) ? baseRx : baseRx + 1'b1;
    strobes.keptNext   = (keep && baseKept != KEPT_MAX) ? baseKept + 1'b1 : baseKept;
    strobes.lenReached = accept & (strobes.rxNext >= {1'b0, effMax});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFrame   <= 1'b0;
      rxCount   <= '0;
      keptCount <= '0;
      maxLenQ   <= '0;
    end else begin
      if (strobes.startFrame) maxLenQ <= cfgMaxLen;
      if (strobes.endFrame) begin
        inFrame   <= 1'b0;
        rxCount   <= '0;
        keptCount <= '0;
      end else if (accept) begin
        inFrame   <= 1'b1;
        rxCount   <= strobes.rxNext;
        keptCount <= strobes.keptNext;
      end
    end
  end

  // A dropped octet only ever appears once the kept count has reached the sampled limit
  p_drop_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !keep) |-> (baseKept == effMax && !cfgHugeEn));

  // Mid-frame the limit in use is the one captured at the start strobe
  p_limit_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inFrame && !(inByteValid && inSof)) |=> (maxLenQ == $past(maxLenQ)));
endmodule

// File: rtl/rx_frame_status_datapath.sv
module rx_frame_status_datapath
  import rx_frame_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [7:0]        inByte,
  input  logic [PART_W-1:0] inPartialBits,
  input  logic              inCodeErr,
  input  logic              inOverrun,
  input  logic              cfgShortEn,
  output logic              outDone,
  output frameStatus_t      outStatus,
  output logic [LEN_W-1:0]  outLength
);
  logic [31:0] crcQ, crcBase, crcNext;
  logic        daAllOnesQ, daAllOnesNext, daAllOnesBase;
  logic        groupQ, groupNext, groupBase;
  logic        lgQ, lgNext;
  logic        trQ, trNext;
  logic        ceQ, ceNext;
  logic        ovQ, ovNext;
  frameStatus_t stNext;

  always_comb begin
    crcBase       = strobes.startFrame ? 32'hFFFF_FFFF : crcQ;
    crcNext       = strobes.keepByte ? crcStep(crcBase, inByte) : crcBase;
    daAllOnesBase = strobes.startFrame ? 1'b1 : daAllOnesQ;
    daAllOnesNext = strobes.daByte ? (daAllOnesBase & (inByte == 8'hFF)) : daAllOnesBase;
    groupBase     = strobes.startFrame ? 1'b0 : groupQ;
    groupNext     = (strobes.daByte && strobes.daIndex == '0) ? inByte[0] : groupBase;
    lgNext = (strobes.startFrame ? 1'b0 : lgQ) | strobes.lenReached;
    trNext = (strobes.startFrame ? 1'b0 : trQ) | (strobes.acceptByte & ~strobes.keepByte);
    ceNext = (strobes.startFrame ? 1'b0 : ceQ) | (strobes.acceptByte & inCodeErr);
    ovNext = (strobes.startFrame ? 1'b0 : ovQ) | (strobes.acceptByte & inOverrun);

    stNext          = '0;
    stNext.bcast    = daAllOnesNext & (strobes.rxNext >= RX_W'(DA_BYTES));
    stNext.mcast    = groupNext & ~stNext.bcast;
    stNext.shortFrm = cfgShortEn & (strobes.keptNext < LEN_W'(MIN_FRAME));
    stNext.overrun  = ovNext;
    if (!ovNext) begin
      stNext.lenViol   = lgNext;
      stNext.truncated = trNext;
      stNext.nonOctet  = (inPartialBits != '0);
      stNext.crcErr    = ceNext | ((inPartialBits == '0) & (crcNext != CRC_GOOD_REG));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcQ       <= 32'hFFFF_FFFF;
      daAllOnesQ <= 1'b1;
      groupQ     <= 1'b0;
      lgQ        <= 1'b0;
      trQ        <= 1'b0;
      ceQ        <= 1'b0;
      ovQ        <= 1'b0;
      outDone    <= 1'b0;
      outStatus  <= '0;
      outLength  <= '0;
    end else begin
      outDone <= strobes.endFrame;
      if (strobes.endFrame) begin
        outStatus  <= stNext;
        outLength  <= strobes.keptNext;
        crcQ       <= 32'hFFFF_FFFF;
        daAllOnesQ <= 1'b1;
        groupQ     <= 1'b0;
        lgQ        <= 1'b0;
        trQ        <= 1'b0;
        ceQ        <= 1'b0;
        ovQ        <= 1'b0;
      end else if (strobes.acceptByte) begin
        crcQ       <= crcNext;
        daAllOnesQ <= daAllOnesNext;
        groupQ     <= groupNext;
        lgQ        <= lgNext;
        trQ        <= trNext;
        ceQ        <= ceNext;
        ovQ        <= ovNext;
      end
    end
  end

  p_bc_mc_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outDone |-> !(outStatus.bcast && outStatus.mcast));

  p_ovr_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outDone && outStatus.overrun) |->
      !(outStatus.lenViol || outStatus.nonOctet || outStatus.crcErr || outStatus.truncated));

  p_trunc_has_lg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outDone && outStatus.truncated) |-> outStatus.lenViol);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rx_frame_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inByteValid,
  input  logic [7:0]        inByte,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [PART_W-1:0] inPartialBits,
  input  logic              inCodeErr,
  input  logic              inOverrun,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic              cfgHugeEn,
  input  logic              cfgShortEn,
  output logic              outDone,
  output logic [7:0]        outStatus,
  output logic [LEN_W-1:0]  outLength
);
  ctlStrobes_t  strobes;
  frameStatus_t statusWord;

  rx_frame_status_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .inByteValid (inByteValid),
    .inSof       (inSof),
    .inEof       (inEof),
    .cfgMaxLen   (cfgMaxLen),
    .cfgHugeEn   (cfgHugeEn),
    .strobes     (strobes)
  );

  rx_frame_status_datapath dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .inByte        (inByte),
    .inPartialBits (inPartialBits),
    .inCodeErr     (inCodeErr),
    .inOverrun     (inOverrun),
    .cfgShortEn    (cfgShortEn),
    .outDone       (outDone),
    .outStatus     (statusWord),
    .outLength     (outLength)
  );

  assign outStatus = statusWord;

  p_done_follows_eof_r12: assert property (@(posedge clk) disable iff (!rst_n)
    outDone |-> $past(inByteValid && inEof));
endmodule

// File: tb/rx_frame_status_tb.sv
module rx_frame_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_BUF    = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inByteValid, inSof, inEof, inCodeErr, inOverrun;
  logic [7:0]  inByte;
  logic [2:0]  inPartialBits;
  logic [15:0] cfgMaxLen;
  logic        cfgHugeEn, cfgShortEn;
  logic        outDone;
  logic [7:0]  outStatus;
  logic [15:0] outLength;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  logic [7:0] frm [MAX_BUF];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_status dut_i (
    .clk(clk), .rst_n(rst_n), .inByteValid(inByteValid), .inByte(inByte),
    .inSof(inSof), .inEof(inEof), .inPartialBits(inPartialBits),
    .inCodeErr(inCodeErr), .inOverrun(inOverrun), .cfgMaxLen(cfgMaxLen),
    .cfgHugeEn(cfgHugeEn), .cfgShortEn(cfgShortEn),
    .outDone(outDone), .outStatus(outStatus), .outLength(outLength)
  );

  function automatic logic [31:0] benchCrc(input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ frm[i][b];
        r = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // daKind: 0 unicast, 1 broadcast, 2 multicast
  task automatic fillFrame(input int len, input int daKind, input bit corrupt);
    logic [31:0] c;
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    if (len > 0) frm[0][0] = 1'b0;
    if (daKind == 1) for (int i = 0; i < 6 && i < len; i++) frm[i] = 8'hFF;
    if (daKind == 2 && len > 0) begin
      frm[0][0] = 1'b1;
      if (len > 1) frm[1] = 8'h00;
    end
    if (len >= 10) begin
      c = ~benchCrc(len - 4);
      for (int k = 0; k < 4; k++) frm[len-4+k] = c[8*k +: 8];
    end
    if (corrupt && len >= 10) frm[len/2] = frm[len/2] ^ 8'h10;
  endtask

  task automatic runFrame(input int len, input logic [2:0] part, input int ceIdx,
                          input int ovIdx, input logic [15:0] maxL, input bit huge,
                          input bit shortEn, input int gapPct, input logic [15:0] midMax,
                          input string lenTag);
    int kept;
    bit bc, mc, lg, tr, no, sh, cr, ov, allFf;
    kept = (huge || len <= int'(maxL)) ? len : int'(maxL);
    allFf = (len >= 6);
    for (int i = 0; i < 6 && i < len; i++) if (frm[i] != 8'hFF) allFf = 0;
    bc = allFf;
    mc = (len >= 1) && frm[0][0] && !bc;
    lg = (len >= int'(maxL));
    tr = !huge && (len > int'(maxL));
    no = (part != 0);
    sh = shortEn && (kept < 64);
    ov = (ovIdx >= 0 && ovIdx < len);
    cr = (ceIdx >= 0 && ceIdx < len) || (!no && benchCrc(kept) != 32'hDEBB20E3);
    if (ov) begin lg = 0; tr = 0; no = 0; cr = 0; end

    cfgMaxLen = maxL; cfgHugeEn = huge; cfgShortEn = shortEn;
    for (int i = 0; i < len; i++) begin
      while (i > 0 && int'($urandom_range(99)) < gapPct) begin
        @(negedge clk);
        inByteValid = 0; inSof = 0; inEof = 0; inCodeErr = 0; inOverrun = 0;
      end
      @(negedge clk);
      inByteValid = 1; inByte = frm[i];
      inSof = (i == 0); inEof = (i == len - 1);
      inCodeErr = (i == ceIdx); inOverrun = (i == ovIdx);
      inPartialBits = (i == len - 1) ? part : 3'($urandom);
      if (i == 1) cfgMaxLen = midMax;
    end
    @(negedge clk);
    inByteValid = 0; inSof = 0; inEof = 0; inCodeErr = 0; inOverrun = 0;
    check("R12 done", int'(outDone), 1);
    check("R1 bcast", int'(outStatus[0]), int'(bc));
    check("R2 mcast", int'(outStatus[1]), int'(mc));
    check("R3 lenViol", int'(outStatus[2]), int'(lg));
    check("R6 nonOctet", int'(outStatus[3]), int'(no));
    check("R5 short", int'(outStatus[4]), int'(sh));
    check("R7 R8 crcErr", int'(outStatus[5]), int'(cr));
    check("R9 overrun", int'(outStatus[6]), int'(ov));
    check("R4 trunc", int'(outStatus[7]), int'(tr));
    check(lenTag, int'(outLength), kept);
    @(negedge clk);
    check("R12 done single", int'(outDone), 0);
    cfgMaxLen = maxL;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; inByteValid = 0; inByte = 0; inSof = 0; inEof = 0;
    inPartialBits = 0; inCodeErr = 0; inOverrun = 0;
    cfgMaxLen = 16'd1518; cfgHugeEn = 0; cfgShortEn = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 reset done", int'(outDone), 0);
    check("R10 reset length", int'(outLength), 0);
    check("R9 reset status", int'(outStatus), 0);

    // Directed corners
    fillFrame(64, 0, 0);  runFrame(64, 0, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(80, 1, 0);  runFrame(80, 0, -1, -1, 16'd1518, 0, 1, 20, 16'd1518, "R10 length");
    fillFrame(80, 2, 0);  runFrame(80, 0, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(100, 0, 0); runFrame(100, 0, -1, -1, 16'd100, 0, 1, 0, 16'd100, "R10 length at limit");
    fillFrame(101, 0, 0); runFrame(101, 0, -1, -1, 16'd100, 0, 1, 0, 16'd100, "R10 truncated length");
    fillFrame(150, 0, 0); runFrame(150, 0, -1, -1, 16'd100, 1, 1, 0, 16'd100, "R10 huge length");
    fillFrame(40, 0, 0);  runFrame(40, 0, -1, -1, 16'd1518, 0, 0, 0, 16'd1518, "R10 length");
    fillFrame(40, 0, 0);  runFrame(40, 0, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(70, 0, 1);  runFrame(70, 0, -1, 30, 16'd60, 0, 1, 0, 16'd60, "R10 length");
    fillFrame(70, 0, 0);  runFrame(70, 0, 12, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(70, 0, 0);  runFrame(70, 3'd5, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(70, 0, 1);  runFrame(70, 0, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 length");
    fillFrame(90, 0, 0);  runFrame(90, 0, -1, -1, 16'd200, 0, 1, 0, 16'd20, "R11 limit sampled at start");
    fillFrame(90, 0, 0);  runFrame(90, 0, -1, -1, 16'd50, 0, 1, 0, 16'd1000, "R11 limit sampled at start");
    fillFrame(1, 0, 0);   runFrame(1, 0, -1, -1, 16'd1518, 0, 1, 0, 16'd1518, "R10 one octet");

    // Constrained random frames
    for (int n = 0; n < 250; n++) begin
      int len, kind, ceI, ovI, g;
      logic [15:0] mx;
      logic [2:0] pb;
      len  = 1 + int'($urandom_range(219));
      kind = int'($urandom_range(2));
      mx   = 16'(40 + $urandom_range(200));
      pb   = ($urandom_range(9) == 0) ? 3'(1 + $urandom_range(6)) : 3'd0;
      ceI  = ($urandom_range(9) == 0) ? int'($urandom_range(len - 1)) : -1;
      ovI  = ($urandom_range(9) == 0) ? int'($urandom_range(len - 1)) : -1;
      g    = ($urandom_range(3) == 0) ? 30 : 0;
      fillFrame(len, kind, $urandom_range(4) == 0);
      runFrame(len, pb, ceI, ovI, mx, 1'($urandom), 1'($urandom), g, mx, "R10 length");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule